// File: doc/BRIEF.md
# I2C Target Engine with Own-Address Match

This block is the target side of a two-wire serial bus port. It watches the bus through synchronizers clocked by the system clock and recognises START and STOP conditions, which set and clear a bus-busy flag. After each START it shifts in the first byte and compares its top seven bits with a programmable own address. The lowest bit of that byte selects the direction of the transfer. On a match the engine acknowledges the byte. A direction of 0 makes the engine receive bytes from the controller, and a direction of 1 makes it send bytes to the controller. An address that does not match leaves the engine silent until the next START.

After each received byte, and before each byte it sends, the engine raises its interrupt and holds the clock line low. The clock is released only by a CPU access to the data register. A read releases it in receive mode and a write releases it in transmit mode. Received bytes are acknowledged during the ninth clock when software has ACK enabled. In transmit mode, a NACK from the controller ends the transfer and sets a sticky status bit. A START seen in the middle of any byte restarts address reception.

The CPU reaches four byte-wide registers through a simple select, write and offset port. Reads of the registers are combinational.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, `sda_oe`, `scl_oe` and `irq` are 0. The status register (offset 3) reads 0x00, the own-address register (offset 1, bits [6:0]) reads 0x00, and the control register (offset 2, bit 0 = ACK enable) reads 0x01.
- R2: Status bit 0 (busy) becomes 1 after a START (SDA falls while SCL is high). It returns to 0 after a STOP (SDA rises while SCL is high).
- R3: The first byte after a START is taken MSB first. When its bits [7:1] equal the own address, SDA is driven low for the ninth clock. Otherwise no ACK is given, and the following bytes raise no interrupt and get no ACK until the next START.
- R4: With direction bit 0, each data byte is taken MSB first. After the falling edge of its eighth clock, `irq` is 1 and `scl_oe` is 1, and a read of the data register (offset 0) returns the byte.
- R5: In receive mode, a read of the data register releases `scl_oe` and clears `irq`. SDA is then low for the ninth clock if ACK enable is 1, and it is released if ACK enable is 0.
- R6: With direction bit 1, after the address ACK, `irq` is 1, `scl_oe` is 1 and status bit 2 (transmit) is 1 until the CPU writes the data register. The written byte is then put on SDA MSB first.
- R7: In transmit mode, an ACK from the controller leads to a new hold with `irq`. A NACK releases SDA, leaves SCL free, keeps `irq` at 0 and sets status bit 3 (NACK seen). The next START clears that bit.
- R8: A START in the middle of a byte discards the partial byte and restarts address reception, so the next full byte is decoded as an address.
- R9: A data-register access outside a hold does not release anything. A read made in the very cycle that a received byte completes returns the earlier register content and leaves SCL held and `irq` set. Status bit 4 mirrors the pending hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Clock line level as seen at the pad |
| sda_in | input | 1 | Data line level as seen at the pad |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Byte-complete interrupt, high while the clock is held |

## Verification
Two things can land in the same cycle: a CPU read of the data register, and the end of a received byte that moves the engine into its hold. The bench times the eighth falling clock edge through the synchronizer depth and places the read strobe exactly in the cycle where the falling edge is decoded. It judges the result in three ways: the read returns the value that was in the register before the byte, the clock stays stretched with the interrupt set, and a later read returns the new byte and only then frees the clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int CW = $clog2(DW + 1);

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_OWN  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_RX,
    S_RXHOLD,
    S_RACK,
    S_TXHOLD,
    S_TX,
    S_TACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = chain[STAGES-1];
    assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[i] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          busy,
  output logic          addressed,
  output logic          xmit,
  output logic          nack,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte
);
  tgt_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          sda_q, sda_d, busy_q, busy_d, dir_q, dir_d;
  logic          nack_q, nack_d, mack_q, mack_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; sda_d = sda_q;
    busy_d = busy_q; dir_d = dir_q; nack_d = nack_q; mack_d = mack_q;
    rx_valid = 1'b0;
    if (stop_evt) begin
      st_d = S_IDLE; sda_d = 1'b0; busy_d = 1'b0;
    end else if (start_evt) begin
      st_d = S_ADDR; cnt_d = '0; sda_d = 1'b0; busy_d = 1'b1; nack_d = 1'b0;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[DW-2:0], sda_lvl}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            if (sh_q[DW-1 -: AW] == own_addr) begin
              st_d = S_AACK; sda_d = 1'b1; dir_d = sh_q[0];
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          sda_d = 1'b0; cnt_d = '0;
          st_d  = dir_q ? S_TXHOLD : S_RX;
        end
        S_RX: begin
          if (scl_rise) begin
            sh_d = {sh_q[DW-2:0], sda_lvl}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            st_d = S_RXHOLD; rx_valid = 1'b1;
          end
        end
        S_RXHOLD: if (rd_stb) begin
          st_d = S_RACK; sda_d = ack_en;
        end
        S_RACK: if (scl_fall) begin
          st_d = S_RX; sda_d = 1'b0; cnt_d = '0;
        end
        S_TXHOLD: if (wr_stb) begin
          st_d = S_TX; sh_d = wdata; sda_d = ~wdata[DW-1]; cnt_d = '0;
        end
        S_TX: if (scl_fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) begin
            st_d = S_TACK; sda_d = 1'b0;
          end else begin
            sh_d = {sh_q[DW-2:0], 1'b0}; sda_d = ~sh_q[DW-2];
          end
        end
        S_TACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          else if (scl_fall) begin
            if (mack_q) st_d = S_TXHOLD;
            else begin
              st_d = S_IDLE; nack_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; sh_q <= '0; sda_q <= 1'b0;
      busy_q <= 1'b0; dir_q <= 1'b0; nack_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; sda_q <= sda_d;
      busy_q <= busy_d; dir_q <= dir_d; nack_q <= nack_d; mack_q <= mack_d;
    end
  end

  assign sda_oe    = sda_q;
  assign scl_oe    = (st_q == S_RXHOLD) || (st_q == S_TXHOLD);
  assign busy      = busy_q;
  assign addressed = !(st_q == S_IDLE || st_q == S_ADDR);
  assign xmit      = dir_q && addressed;
  assign nack      = nack_q;
  assign rx_byte   = sh_q;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter logic [AW-1:0] RST_OWN = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] status,
  output logic [AW-1:0] own_addr,
  output logic          ack_en,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] bus_rdata
);
  logic [AW-1:0] own_q;
  logic          ack_q;
  logic [DW-1:0] data_q, data_d;
  logic          own_en, ctrl_en, data_en;

  assign rd_stb  = bus_sel && !bus_wr && bus_addr == RA_DATA;
  assign wr_stb  = bus_sel &&  bus_wr && bus_addr == RA_DATA;
  assign own_en  = bus_sel &&  bus_wr && bus_addr == RA_OWN;
  assign ctrl_en = bus_sel &&  bus_wr && bus_addr == RA_CTRL;
  assign data_en = rx_valid || wr_stb;

  always_comb data_d = rx_valid ? rx_byte : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= RST_OWN; ack_q <= 1'b1; data_q <= '0;
    end else begin
      if (own_en)  own_q  <= bus_wdata[AW-1:0];
      if (ctrl_en) ack_q  <= bus_wdata[0];
      if (data_en) data_q <= data_d;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_DATA: bus_rdata = data_q;
      RA_OWN:  bus_rdata = {{(DW-AW){1'b0}}, own_q};
      RA_CTRL: bus_rdata = {{(DW-1){1'b0}}, ack_q};
      default: bus_rdata = status;
    endcase
  end

  assign own_addr = own_q;
  assign ack_en   = ack_q;
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] RST_OWN     = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [1:0] rst_ff;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  logic [1:0] lvl, rise, fall;
  i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din({scl_in, sda_in}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  logic start_evt, stop_evt, scl_steady;
  assign scl_steady = lvl[1] && !rise[1];
  assign start_evt  = scl_steady && fall[0];
  assign stop_evt   = scl_steady && rise[0];

  logic [AW-1:0] own_addr;
  logic          ack_en, rd_stb, wr_stb, rx_valid;
  logic          busy, addressed, xmit, nack;
  logic [DW-1:0] rx_byte, status;

  i2c_tgt_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(rise[1]), .scl_fall(fall[1]), .sda_lvl(lvl[0]),
    .own_addr(own_addr), .ack_en(ack_en), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(bus_wdata), .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy),
    .addressed(addressed), .xmit(xmit), .nack(nack),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  assign irq    = scl_oe;
  assign status = {{(DW-5){1'b0}}, irq, nack, xmit, addressed, busy};

  i2c_tgt_regs #(.RST_OWN(RST_OWN)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .status(status), .own_addr(own_addr), .ack_en(ack_en),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       busy,
  input logic       xmit,
  input logic       stop_evt
);
  logic data_acc;
  assign data_acc = bus_sel && bus_addr == 2'd0;

  // R2: busy only drops right after a decoded STOP
  a_r2_busy_drops_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(stop_evt));

  // R3: a free bus is never driven
  a_r3_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_oe && !scl_oe));

  // R4: the stretch begins only while the clock line is already low
  a_r4_stretch_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_in);

  // R5: a data read in a receive hold frees the clock
  a_r5_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !xmit && data_acc && !bus_wr) |=> !scl_oe);

  // R6: a data write in a transmit hold frees the clock
  a_r6_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && xmit && data_acc && bus_wr) |=> !scl_oe);

  // R9: without a data access the hold persists
  a_r9_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !data_acc) |=> scl_oe);
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .scl_oe(scl_oe), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy(busy), .xmit(xmit), .stop_evt(stop_evt)
);

// File: tb/sim_i2c_tgt.sv
`timescale 1ns/1ps
module sim_i2c_tgt;
  localparam int Q  = 6;
  localparam int NV = 5;
  // {own[24:18], address byte[17:10], data[9:2], ack enable[1], expect match[0]}
  localparam logic [24:0] VEC [NV] = '{
    {7'h50, 8'hA0, 8'hC3, 1'b1, 1'b1},
    {7'h50, 8'hA2, 8'h3C, 1'b1, 1'b0},
    {7'h7F, 8'hFE, 8'h00, 1'b0, 1'b1},
    {7'h01, 8'h02, 8'hFF, 1'b1, 1'b1},
    {7'h2A, 8'h56, 8'h81, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic scl_oe, sda_oe, irq;
  wire  scl_line = scl_m & ~scl_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   nvec = 0, nmis = 0;

  always #10 clk = ~clk;

  i2c_tgt u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
    r = sda_line; scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_byte(input logic [7:0] d, output logic [7:0] r);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit(d[i], b); r[i] = b;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin : stim
    logic [7:0] s, d, r8;
    logic a;
    logic [24:0] e;
    // R1: reset state
    tick(3);
    chk("R1 sda_oe in reset", {7'b0, sda_oe}, 8'h00);
    chk("R1 scl_oe in reset", {7'b0, scl_oe}, 8'h00);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1; tick(4);
    cpu_rd(2'd3, s); chk("R1 status after reset", s, 8'h00);
    cpu_rd(2'd1, s); chk("R1 own address after reset", s, 8'h00);
    cpu_rd(2'd2, s); chk("R1 control after reset", s, 8'h01);

    // table walk: write transfers, R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      cpu_wr(2'd1, {1'b0, e[24:18]});
      cpu_wr(2'd2, {7'b0, e[1]});
      m_start();
      cpu_rd(2'd3, s); chk("R2 busy after START", {7'b0, s[0]}, 8'h01);
      m_byte(e[17:10], r8);
      m_bit(1'b1, a);
      chk("R3 address ACK level", {7'b0, a}, {7'b0, !e[0]});
      m_byte(e[9:2], r8);
      if (e[0]) begin
        chk("R4 irq after byte", {7'b0, irq}, 8'h01);
        chk("R4 clock stretched", {7'b0, scl_oe}, 8'h01);
        cpu_rd(2'd0, d); chk("R4 received byte", d, e[9:2]);
        tick(2);
        chk("R5 clock released by read", {7'b0, scl_oe}, 8'h00);
        chk("R5 irq cleared by read", {7'b0, irq}, 8'h00);
        m_bit(1'b1, a);
        chk("R5 data ACK follows enable", {7'b0, a}, {7'b0, !e[1]});
      end else begin
        chk("R3 ignored byte raises no irq", {7'b0, irq}, 8'h00);
        m_bit(1'b1, a);
        chk("R3 ignored byte gets no ACK", {7'b0, a}, 8'h01);
      end
      m_stop();
      cpu_rd(2'd3, s); chk("R2 free after STOP", {7'b0, s[0]}, 8'h00);
    end

    // R6 R7: transmit with ACK then NACK
    cpu_wr(2'd1, 8'h33);
    cpu_wr(2'd2, 8'h01);
    m_start();
    m_byte(8'h67, r8);
    m_bit(1'b1, a); chk("R6 read address ACK", {7'b0, a}, 8'h00);
    tick(2);
    chk("R6 irq before first byte", {7'b0, irq}, 8'h01);
    chk("R6 clock held before first byte", {7'b0, scl_oe}, 8'h01);
    cpu_rd(2'd3, s); chk("R6 transmit status bit", {7'b0, s[2]}, 8'h01);
    cpu_wr(2'd0, 8'hA5);
    m_byte(8'hFF, r8); chk("R6 first byte on SDA", r8, 8'hA5);
    m_bit(1'b0, a);
    chk("R7 ACK leads to new hold", {7'b0, irq}, 8'h01);
    cpu_wr(2'd0, 8'h5A);
    m_byte(8'hFF, r8); chk("R6 second byte on SDA", r8, 8'h5A);
    m_bit(1'b1, a);
    chk("R7 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
    chk("R7 no stretch after NACK", {7'b0, scl_oe}, 8'h00);
    chk("R7 no irq after NACK", {7'b0, irq}, 8'h00);
    cpu_rd(2'd3, s); chk("R7 NACK status bit", {7'b0, s[3]}, 8'h01);
    m_stop();
    m_start();
    cpu_rd(2'd3, s); chk("R7 NACK bit cleared by START", {7'b0, s[3]}, 8'h00);
    m_stop();

    // R8: repeated START after three address bits
    cpu_wr(2'd1, 8'h11);
    m_start();
    m_bit(1'b0, a); m_bit(1'b1, a); m_bit(1'b1, a);
    m_start();
    m_byte(8'h22, r8);
    m_bit(1'b1, a); chk("R8 address after repeated START", {7'b0, a}, 8'h00);
    m_stop();

    // R9: data read in the cycle the byte completes
    cpu_wr(2'd1, 8'h40);
    cpu_wr(2'd0, 8'h99);
    tick(2);
    chk("R9 write outside hold leaves clock free", {7'b0, scl_oe}, 8'h00);
    m_start();
    m_byte(8'h80, r8);
    m_bit(1'b1, a);
    for (int i = 7; i >= 1; i--) m_bit(i[0], a);
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
    scl_m = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
    chk("R9 same-cycle read returns old content", d, 8'h99);
    tick(2);
    chk("R9 clock still held", {7'b0, scl_oe}, 8'h01);
    chk("R9 irq still set", {7'b0, irq}, 8'h01);
    cpu_rd(2'd3, s); chk("R9 pending status bit", {7'b0, s[4]}, 8'h01);
    cpu_rd(2'd0, d); chk("R9 later read returns new byte", d, 8'hAA);
    tick(2);
    chk("R9 later read frees clock", {7'b0, scl_oe}, 8'h00);
    m_bit(1'b1, a);
    m_stop();

    tick(4);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule